// File: doc/BRIEF.md
# Three-Phase Sine Reference Generator

This block produces the three sinusoidal reference samples that a carrier-based PWM modulator compares against its triangle carrier. One phase accumulator advances by a programmable frequency word each time the clock enable pulses. The enable is expected to come from a divider of the base clock, so the output frequency is set by the enable rate and the word together. The three outputs are taps on that accumulator, one third of a turn apart. Each tap reads a table that only covers the positive half of a sine, and the half-cycle bit of the phase decides whether the table value is negated. A modulation index then scales each signed sample.

The default accumulator is 24 bits wide. With an enable of 10 MHz divided down to around 100 kHz, the resolution is about 6 mHz per word step, and the fundamental can be placed anywhere from well below 0.1 Hz up to 1.5 kHz and beyond. The frequency word and the index may be changed while the block is running. A new set of samples is flagged with a one-cycle valid strobe. Between strobes the outputs hold their last values.

Top module: `tri_sine_ref`

## Requirements
- R1: While rst_n is low at a clock edge, the accumulator clears to 0, phase_valid goes low and all three samples go to 0. The first enable after reset therefore produces phase A at zero degrees.
- R2: phase_valid is high for exactly one cycle, two clock edges after each edge at which step_en is high, and it is never high otherwise.
- R3: On each edge with step_en high, the 24-bit accumulator adds freq_word modulo 2^24. With step_en low it holds, whatever freq_word does.
- R4: A tap's phase p is 24 bits wide. Bit 23 of p is the half-cycle bit, and bits 22:15 form the table address k (0..255). The table magnitude is mag(k) = floor(32767 * 16k(256-k) / (5*65536 - 4k(256-k))).
- R5: When the half-cycle bit of p is 1, the sample is the two's-complement negation of the scaled magnitude. When it is 0, the sample is the scaled magnitude itself.
- R6: Phase A uses p = acc. Phase B uses p = acc + 0x555555 and phase C uses p = acc + 0xAAAAAA, both modulo 2^24.
- R7: The scaled magnitude is floor(mag(k) * m / 32768), where m is the unsigned Q1.15 modulation index, so 0x8000 means 1.0.
- R8: An index above 0x8000 is treated as exactly 0x8000. No sample ever takes the value -32768.
- R9: freq_word and mod_index are sampled on the enable edge. The samples for that enable use the accumulator value from before that edge's addition, together with that edge's index.
- R10: While phase_valid is low, the three samples keep the values they held in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Synchronous active-low reset |
| step_en | input | 1 | Divided-rate enable; one accumulator step per high cycle |
| freq_word | input | ACC_W (24) | Phase increment per enable |
| mod_index | input | MI_W (16) | Unsigned Q1.15 modulation index |
| phase_a | output | SAMP_W (16) | Signed reference, phase A |
| phase_b | output | SAMP_W (16) | Signed reference, phase B, +120 degrees |
| phase_c | output | SAMP_W (16) | Signed reference, phase C, +240 degrees |
| phase_valid | output | 1 | One-cycle strobe marking fresh samples |

## Verification
The case that needs care is a new frequency word and a new modulation index arriving on the same enable edge. In that cycle the accumulator addition and the sample capture both happen. The bench changes both inputs in one enable pulse and also does so in the middle of a continuous enable burst. It then judges the result against a model in which that sample carries the new index but the old phase, and the following sample is the first to show the new frequency step. Wrap of the accumulator is provoked in the same bursts by using large words, and the half-cycle sign flip is provoked there too.

// File: rtl/tsr_pkg.sv
// Shared helpers for the three-phase sine reference.
// Assumes address widths of at most 16 bits so the 64-bit arithmetic cannot overflow.
package tsr_pkg;

    // Rational half-sine approximation, evaluated at elaboration time only.
    function automatic longint half_sine_mag(input longint k, input int addr_w, input int mag_w);
        longint n;
        longint amax;
        longint q;
        n    = longint'(1) << addr_w;
        amax = (longint'(1) << mag_w) - 1;
        q    = k * (n - k);
        return (amax * 16 * q) / (5 * n * n - 4 * q);
    endfunction

endpackage

// File: rtl/tsr_phase_acc.sv
// Phase accumulator: adds the frequency word once per enable, wrapping modulo 2^ACC_W.
// Assumes the enable is a single-cycle qualifier from an external divider.
module tsr_phase_acc #(
    parameter int ACC_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_en,
    input  logic [ACC_W-1:0] freq_word,
    output logic [ACC_W-1:0] acc
);

    // Advance the phase on each enable; clear it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)       acc <= '0;
        else if (step_en) acc <= acc + freq_word;
    end

endmodule

// File: rtl/tsr_half_sine_rom.sv
// Half-cycle sine magnitude table. The contents are computed at elaboration; the read is combinational.
// Assumes 2^ADDR_W entries spanning 0 to just under 180 degrees.
module tsr_half_sine_rom #(
    parameter int ADDR_W = 8,
    parameter int MAG_W  = 15
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [MAG_W-1:0]  mag
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [MAG_W-1:0] table_q [DEPTH];

    // Fill every entry from the approximation function.
    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        assign table_q[i] = MAG_W'(tsr_pkg::half_sine_mag(longint'(i), ADDR_W, MAG_W));
    end

    // Combinational read of the selected entry.
    assign mag = table_q[addr];

endmodule

// File: rtl/tsr_phase_shaper.sv
// One output phase: offsets the shared accumulator, looks up the half-sine, scales it and applies the sign.
// Stage 1 captures address, sign and index on the enable. Stage 2 registers the signed sample on load.
module tsr_phase_shaper #(
    parameter int               ACC_W  = 24,
    parameter int               ADDR_W = 8,
    parameter int               SAMP_W = 16,
    parameter int               MI_W   = 16,
    parameter logic [ACC_W-1:0] OFFSET = '0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     step_en,
    input  logic                     load,
    input  logic [ACC_W-1:0]         acc,
    input  logic [MI_W-1:0]          mi_eff,
    output logic signed [SAMP_W-1:0] samp
);

    localparam int MAG_W  = SAMP_W - 1;
    localparam int PROD_W = MAG_W + MI_W;
    localparam int FRAC   = MI_W - 1;

    logic [ACC_W-1:0]  tap;
    logic              neg_q;
    logic [ADDR_W-1:0] addr_q;
    logic [MI_W-1:0]   mi_q;
    logic [MAG_W-1:0]  mag;
    logic [PROD_W-1:0] prod;
    logic [MAG_W-1:0]  scaled;
    logic [SAMP_W-1:0] pos_val;
    logic [SAMP_W-1:0] samp_d;

    assign tap = acc + OFFSET;

    // Capture this phase's half-cycle bit, table address and index on the enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            neg_q  <= 1'b0;
            addr_q <= '0;
            mi_q   <= '0;
        end else if (step_en) begin
            neg_q  <= tap[ACC_W-1];
            addr_q <= tap[ACC_W-2 -: ADDR_W];
            mi_q   <= mi_eff;
        end
    end

    tsr_half_sine_rom #(.ADDR_W(ADDR_W), .MAG_W(MAG_W)) u_rom (
        .addr (addr_q),
        .mag  (mag)
    );

    // Scale by the Q1.15 index and truncate back to the magnitude width.
    always_comb begin
        prod    = PROD_W'(mag) * PROD_W'(mi_q);
        scaled  = MAG_W'(prod >> FRAC);
        pos_val = {1'b0, scaled};
        samp_d  = neg_q ? (~pos_val + 1'b1) : pos_val;
    end

    // Register the signed sample when the pipeline delivers a new one.
    always_ff @(posedge clk) begin
        if (!rst_n)    samp <= '0;
        else if (load) samp <= signed'(samp_d);
    end

endmodule

// File: rtl/tri_sine_ref.sv
// Three-phase sine reference: one accumulator feeds three taps spaced one third of a turn apart.
// Latency is two clock edges from an enable to the valid strobe. Outputs hold between strobes.
module tri_sine_ref #(
    parameter int ACC_W  = 24,
    parameter int ADDR_W = 8,
    parameter int SAMP_W = 16,
    parameter int MI_W   = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     step_en,
    input  logic [ACC_W-1:0]         freq_word,
    input  logic [MI_W-1:0]          mod_index,
    output logic signed [SAMP_W-1:0] phase_a,
    output logic signed [SAMP_W-1:0] phase_b,
    output logic signed [SAMP_W-1:0] phase_c,
    output logic                     phase_valid
);

    localparam int               NPH      = 3;
    localparam logic [ACC_W-1:0] THIRD    = ACC_W'((longint'(1) << ACC_W) / 3);
    localparam logic [MI_W-1:0]  UNITY    = MI_W'(1) << (MI_W - 1);

    logic [ACC_W-1:0]         phase_acc;
    logic [MI_W-1:0]          mi_eff;
    logic                     stage1_vld;
    logic signed [SAMP_W-1:0] samp_arr [NPH];

    tsr_phase_acc #(.ACC_W(ACC_W)) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_en   (step_en),
        .freq_word (freq_word),
        .acc       (phase_acc)
    );

    // Limit the modulation index to 1.0 so the scaled sample cannot overflow.
    assign mi_eff = (mod_index > UNITY) ? UNITY : mod_index;

    // Two-stage valid pipeline that tracks the sample path.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_vld  <= 1'b0;
            phase_valid <= 1'b0;
        end else begin
            stage1_vld  <= step_en;
            phase_valid <= stage1_vld;
        end
    end

    for (genvar p = 0; p < NPH; p++) begin : g_phase
        tsr_phase_shaper #(
            .ACC_W  (ACC_W),
            .ADDR_W (ADDR_W),
            .SAMP_W (SAMP_W),
            .MI_W   (MI_W),
            .OFFSET (ACC_W'(THIRD * p))
        ) u_shaper (
            .clk     (clk),
            .rst_n   (rst_n),
            .step_en (step_en),
            .load    (stage1_vld),
            .acc     (phase_acc),
            .mi_eff  (mi_eff),
            .samp    (samp_arr[p])
        );
    end

    assign phase_a = samp_arr[0];
    assign phase_b = samp_arr[1];
    assign phase_c = samp_arr[2];

endmodule

// File: rtl/tsr_checks.sv
// Property checker for tri_sine_ref, attached by bind. It watches ports and the shared accumulator.
module tsr_checks #(
    parameter int ACC_W  = 24,
    parameter int SAMP_W = 16
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     step_en,
    input logic [ACC_W-1:0]         freq_word,
    input logic [ACC_W-1:0]         acc,
    input logic signed [SAMP_W-1:0] phase_a,
    input logic signed [SAMP_W-1:0] phase_b,
    input logic signed [SAMP_W-1:0] phase_c,
    input logic                     phase_valid
);

    localparam logic [SAMP_W-1:0] MOST_NEG = {1'b1, {(SAMP_W-1){1'b0}}};

    logic en_d;

    // Delayed enable, so the valid strobe can be related to the enable two edges back.
    always_ff @(posedge clk) begin
        if (!rst_n) en_d <= 1'b0;
        else        en_d <= step_en;
    end

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (!phase_valid && acc == '0 && phase_a == '0 && phase_b == '0 && phase_c == '0));

    p_valid_after_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
        en_d |=> phase_valid);

    p_no_spurious_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !en_d |=> !phase_valid);

    p_acc_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        step_en |=> acc == ACC_W'($past(acc) + $past(freq_word)));

    p_acc_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !step_en |=> $stable(acc));

    p_no_min_value_r8: assert property (@(posedge clk) disable iff (!rst_n)
        phase_valid |-> (phase_a != MOST_NEG && phase_b != MOST_NEG && phase_c != MOST_NEG));

    p_hold_outputs_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !phase_valid |-> ($stable(phase_a) && $stable(phase_b) && $stable(phase_c)));

endmodule

bind tri_sine_ref tsr_checks #(.ACC_W(ACC_W), .SAMP_W(SAMP_W)) u_tsr_checks (
    .clk         (clk),
    .rst_n       (rst_n),
    .step_en     (step_en),
    .freq_word   (freq_word),
    .acc         (phase_acc),
    .phase_a     (phase_a),
    .phase_b     (phase_b),
    .phase_c     (phase_c),
    .phase_valid (phase_valid)
);

// File: tb/tri_sine_ref_bench.sv
// Scoreboard bench: the driver pushes the expected samples per enable and the monitor compares them on each strobe.
module tri_sine_ref_bench;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               step_en = 1'b0;
    logic [23:0]        freq_word = '0;
    logic [15:0]        mod_index = '0;
    logic signed [15:0] phase_a, phase_b, phase_c;
    logic               phase_valid;

    always #5 clk = ~clk;

    tri_sine_ref u_tri_sine_ref (
        .clk         (clk),
        .rst_n       (rst_n),
        .step_en     (step_en),
        .freq_word   (freq_word),
        .mod_index   (mod_index),
        .phase_a     (phase_a),
        .phase_b     (phase_b),
        .phase_c     (phase_c),
        .phase_valid (phase_valid)
    );

    typedef struct {
        logic signed [15:0] a;
        logic signed [15:0] b;
        logic signed [15:0] c;
    } exp_t;

    exp_t               sb_q[$];
    longint unsigned    m_acc = 0;
    int                 checks = 0;
    int                 fails = 0;
    int                 valid_seen = 0;
    bit                 done = 0;
    logic signed [15:0] last_a = '0, last_b = '0, last_c = '0;

    // Magnitude from the formula in R4.
    function automatic longint mag_of(input longint k);
        longint q;
        q = k * (256 - k);
        return (32767 * 16 * q) / (5 * 65536 - 4 * q);
    endfunction

    // Expected signed sample for one tap (R4 to R8).
    function automatic logic signed [15:0] exp_samp(input longint unsigned acc, input longint unsigned off,
                                                    input longint unsigned mi);
        longint unsigned p;
        longint unsigned mc;
        longint          s;
        p  = (acc + off) & 64'hFFFFFF;
        mc = (mi > 32768) ? 32768 : mi;
        s  = (mag_of(longint'((p >> 15) & 255)) * longint'(mc)) >> 15;
        if (((p >> 23) & 1) == 1) s = -s;
        return 16'(s);
    endfunction

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive one cycle; when the enable is set, push the expected samples and step the model (R3, R9).
    task automatic drive(input logic en, input logic [23:0] fw, input logic [15:0] mi);
        exp_t e;
        @(negedge clk);
        step_en   = en;
        freq_word = fw;
        mod_index = mi;
        if (en) begin
            e.a = exp_samp(m_acc, 0, mi);
            e.b = exp_samp(m_acc, 24'h555555, mi);
            e.c = exp_samp(m_acc, 24'hAAAAAA, mi);
            sb_q.push_back(e);
            m_acc = (m_acc + fw) & 64'hFFFFFF;
        end
    endtask

    task automatic burst(input int n, input logic [23:0] fw, input logic [15:0] mi);
        for (int i = 0; i < n; i++) drive(1'b1, fw, mi);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(1'b0, freq_word, mod_index);
    endtask

    // Monitor: pop and compare on every strobe.
    always @(negedge clk) begin
        if (rst_n && phase_valid) begin
            valid_seen++;
            if (sb_q.size() == 0) begin
                chk("R2 strobe without enable", 1, 0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                chk("R4 R5 R7 phase A", phase_a, e.a);
                chk("R6 phase B", phase_b, e.b);
                chk("R6 phase C", phase_c, e.c);
            end
            last_a = phase_a;
            last_b = phase_b;
            last_c = phase_c;
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #(10 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int v0;
        // R1: reset state.
        repeat (3) @(negedge clk);
        chk("R1 valid in reset", phase_valid, 0);
        chk("R1 phase_a in reset", phase_a, 0);
        chk("R1 phase_c in reset", phase_c, 0);
        rst_n = 1'b1;
        idle(2);

        // R2: a single enable gives exactly one strobe; phase A starts at zero (R1).
        v0 = valid_seen;
        drive(1'b1, 24'h000000, 16'h8000);
        idle(6);
        chk("R2 single strobe count", valid_seen - v0, 1);
        chk("R1 first sample at zero", last_a, 0);

        // R4 R5: one full cycle at full index.
        burst(256, 24'h010000, 16'h8000);
        idle(4);

        // R7: partial indices with an odd step.
        burst(40, 24'h00A3D7, 16'h4000);
        burst(40, 24'h013579, 16'h1234);
        idle(4);

        // R8: indices above unity saturate.
        burst(30, 24'h02468A, 16'hFFFF);
        burst(30, 24'h031111, 16'h8001);
        idle(4);

        // R3: wrap with a large word.
        burst(50, 24'hFFF000, 16'h7000);
        burst(20, 24'hABCDEF, 16'h8000);
        idle(4);

        // R3 R10: enable low while the word changes; the phase and the outputs hold.
        for (int i = 0; i < 20; i++) drive(1'b0, 24'h7FFFFF ^ 24'(i), 16'h2000);
        chk("R10 phase_a held", phase_a, last_a);
        chk("R10 phase_b held", phase_b, last_b);
        chk("R10 phase_c held", phase_c, last_c);
        drive(1'b1, 24'h000000, 16'h8000);
        idle(4);

        // R9: word and index change together, both as a lone pulse and in a running burst.
        drive(1'b1, 24'h2AAAAA, 16'h3000);
        drive(1'b1, 24'h001000, 16'h6000);
        idle(3);
        burst(10, 24'h040000, 16'h8000);
        burst(10, 24'h1C7000, 16'h2800);
        idle(4);

        // R1: mid-run reset clears the phase.
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 valid after mid reset", phase_valid, 0);
        chk("R1 phase_b after mid reset", phase_b, 0);
        rst_n = 1'b1;
        m_acc = 0;
        sb_q.delete();
        burst(12, 24'h0F0F0F, 16'h8000);
        idle(5);

        chk("R2 all expected strobes seen", sb_q.size(), 0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule